// File: doc/BRIEF.md
# Sliding-Window CFAR Detector with Averaging, Greatest-Of and Smallest-Of Noise Estimation

This block takes one range profile of unsigned magnitude samples and decides for every cell whether it stands out from its local background. A frame is first written into an internal buffer. Then the block scans every cell in ascending index order. For each cell under test it keeps two running sums of training cells, one on the lower-index side and one on the higher-index side. A programmable number of guard cells next to the cell is left out of both sums. From the two sums the block forms a noise estimate in one of three ways: the mean of both sides together, the mean of the side with the larger mean, or the mean of the side with the smaller mean. The cell is reported as a detection when its magnitude is strictly greater than a programmable scale factor times that estimate.

The scale factor is unsigned fixed point with four integer and four fractional bits. The whole decision is made without a divider. The greater-of and smaller-of choice compares each side's sum multiplied by the other side's cell count. The threshold test compares magnitude times count times sixteen against scale times sum at full width. The noise path is split over four register stages, so a sum never feeds the selection and the multipliers in the same cycle. Each cell produces one result, which carries the cell index, the stored magnitude, the detection flag and an end-of-frame marker.

Top module: `cfar_detector`

## Requirements
- R1: While reset is low and in the first cycles after it rises, out_valid is low. A reset in the middle of a frame discards that frame, and the next frame is processed as if it were the first.
- R2: Samples are written at indices 0, 1, 2 and onward, one for each cycle with in_valid high, while the block is filling. in_last ends the fill. A frame of N samples produces exactly N results with out_idx 0 to N-1 in order, and out_last is high on the result for index N-1 only.
- R3: The buffer holds DEPTH samples. A frame that reaches DEPTH samples without in_last ends at index DEPTH-1. Any further samples offered while that frame is being processed are discarded.
- R4: For cell i with guard count G and training count T, the leading side covers indices i-G-T to i-G-1 and the lagging side covers i+G+1 to i+G+T. Only indices from 0 to N-1 are counted, and a side with no such index has a count of zero.
- R5: cfg_mode values 0 and 3 select averaging. The cell is a hit when mag × (nL+nG) × 16 > alpha × (SL+SG).
- R6: cfg_mode 1 selects greatest-of. The side with the larger mean is used, judged by SL×nG against SG×nL. If one side has a count of zero, the other side is used.
- R7: cfg_mode 2 selects smallest-of. The side with the smaller mean is used, with the same rule for an empty side.
- R8: The comparison is strict, so a magnitude equal to the threshold is not a hit. A cell with no training cells on either side is never a hit, and a magnitude of zero is never a hit.
- R9: cfg_alpha is unsigned with four fractional bits (16 means 1.0). It is applied at full product width, so a fractional scale changes the decision exactly.
- R10: cfg_mode, cfg_guard, cfg_train and cfg_alpha are sampled with the first sample of a frame. Changing them later in the frame has no effect on its results.
- R11: Samples offered while a frame is being scanned or drained are ignored. They produce no extra results and do not change the results.
- R12: out_mag equals the stored magnitude of cell out_idx, and out_hit is low whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Magnitude sample present |
| in_mag | input | MAG_W | Unsigned magnitude sample |
| in_last | input | 1 | Marks the final sample of a frame |
| cfg_mode | input | 2 | Noise mode: 0/3 averaging, 1 greatest-of, 2 smallest-of |
| cfg_guard | input | GUARD_W | Guard cells per side |
| cfg_train | input | TRAIN_W | Training cells per side |
| cfg_alpha | input | ALPHA_W | Threshold scale, ALPHA_FRAC fractional bits |
| out_valid | output | 1 | Result present |
| out_hit | output | 1 | Cell declared a detection |
| out_idx | output | log2(DEPTH) | Index of the cell under test |
| out_mag | output | MAG_W | Stored magnitude of the cell |
| out_last | output | 1 | Result for the final cell of the frame |

## Verification
A faulty running sum does not stay local. It carries forward into every later cell of the frame, so a single wrong add or remove shows up as wrong out_hit values in a run of cells until the window has passed the damaged entry, and it appears four cycles after the affected cell is scanned. Faults in the edge handling show in the first and last G+T cells of a profile. Faults in the greater-of or smaller-of choice show on step-shaped profiles, where the two sides disagree. A control fault, such as a frame that does not end, a restart during the scan or a configuration sampled too late, shows at once as a missing or extra out_last, out-of-order indices, or results that follow a scale or mode applied after the frame began.

// File: rtl/cfar_pkg.sv
// Shared types for the CFAR detector: noise-estimation modes and the
// frame sequencing states.
package cfar_pkg;
    typedef enum logic [1:0] {
        MODE_CA     = 2'd0,
        MODE_GO     = 2'd1,
        MODE_SO     = 2'd2,
        MODE_CA_ALT = 2'd3
    } cfar_mode_e;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } cfar_state_e;
endpackage

// File: rtl/cfar_mag_store.sv
// Magnitude buffer: one write port and NRD combinational read ports.
// Assumes DEPTH is a power of two, so every AW-bit address is in range.
// Reads of entries not written in the current frame return stale data.
// The caller gates such reads away.
module cfar_mag_store #(
    parameter int MAG_W = 17,
    parameter int DEPTH = 2048,
    parameter int NRD   = 5,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [MAG_W-1:0]          wr_data,
    input  logic [NRD-1:0][AW-1:0]    rd_addr,
    output logic [NRD-1:0][MAG_W-1:0] rd_data
);
    logic [MAG_W-1:0] mem [DEPTH];

    // Store one sample per accepted input cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // One independent read port per window tap.
    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rd_data[k] = mem[rd_addr[k]];
    end
endmodule

// File: rtl/cfar_window.sv
// Sliding training-window engine. On go it places a virtual cell position
// G+T+1 cells before index 0, where both windows are empty. Each cycle it
// adds the entry entering each window and removes the entry leaving it.
// Entries outside 0..N-1 are gated to zero. One cell is emitted per cycle
// once the position is non-negative, ending with cell N-1.
// Assumes n_len >= 1 and stable inputs for the whole scan.
module cfar_window #(
    parameter int MAG_W   = 17,
    parameter int AW      = 11,
    parameter int GUARD_W = 4,
    parameter int TRAIN_W = 6,
    localparam int SUM_W  = MAG_W + TRAIN_W,
    localparam int MX     = (AW > TRAIN_W) ? ((AW > GUARD_W) ? AW : GUARD_W)
                                           : ((TRAIN_W > GUARD_W) ? TRAIN_W : GUARD_W),
    localparam int PW     = MX + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic [AW:0]             n_len,
    input  logic [GUARD_W-1:0]      guard,
    input  logic [TRAIN_W-1:0]      train,
    output logic [4:0][AW-1:0]      rd_addr,
    input  logic [4:0][MAG_W-1:0]   rd_data,
    output logic                    em_valid,
    output logic                    em_last,
    output logic [AW-1:0]           em_idx,
    output logic [MAG_W-1:0]        em_mag,
    output logic [SUM_W-1:0]        em_lsum,
    output logic [SUM_W-1:0]        em_gsum,
    output logic [TRAIN_W-1:0]      em_lcnt,
    output logic [TRAIN_W-1:0]      em_gcnt
);
    localparam logic signed [PW-1:0] ZERO = '0;
    localparam logic signed [PW-1:0] ONE  = PW'(1);

    logic                    active;
    logic signed [PW-1:0]    pos;
    logic [SUM_W-1:0]        lsum, gsum;
    logic [TRAIN_W-1:0]      lcnt, gcnt;
    logic signed [PW-1:0]    g_s, t_s, n_s;
    logic signed [PW-1:0]    i_la, i_lr, i_ga, i_gr;
    logic                    v_la, v_lr, v_ga, v_gr;
    logic [MAG_W-1:0]        d_la, d_lr, d_ga, d_gr;

    assign g_s = $signed({{(PW-GUARD_W){1'b0}}, guard});
    assign t_s = $signed({{(PW-TRAIN_W){1'b0}}, train});
    assign n_s = $signed({{(PW-AW-1){1'b0}}, n_len});

    // Tap positions for the step from pos to pos+1.
    assign i_la = pos - g_s;
    assign i_lr = pos - g_s - t_s;
    assign i_ga = pos + g_s + t_s + ONE;
    assign i_gr = pos + g_s + ONE;

    // A tap counts only when it points inside the stored frame.
    assign v_la = (i_la >= ZERO) && (i_la < n_s);
    assign v_lr = (i_lr >= ZERO) && (i_lr < n_s);
    assign v_ga = (i_ga >= ZERO) && (i_ga < n_s);
    assign v_gr = (i_gr >= ZERO) && (i_gr < n_s);

    assign rd_addr[0] = pos[AW-1:0];
    assign rd_addr[1] = i_la[AW-1:0];
    assign rd_addr[2] = i_lr[AW-1:0];
    assign rd_addr[3] = i_ga[AW-1:0];
    assign rd_addr[4] = i_gr[AW-1:0];

    assign d_la = v_la ? rd_data[1] : '0;
    assign d_lr = v_lr ? rd_data[2] : '0;
    assign d_ga = v_ga ? rd_data[3] : '0;
    assign d_gr = v_gr ? rd_data[4] : '0;

    // The current cell leaves for the noise pipeline with its window sums.
    assign em_valid = active && (pos >= ZERO);
    assign em_last  = em_valid && (pos == n_s - ONE);
    assign em_idx   = pos[AW-1:0];
    assign em_mag   = rd_data[0];
    assign em_lsum  = lsum;
    assign em_gsum  = gsum;
    assign em_lcnt  = lcnt;
    assign em_gcnt  = gcnt;

    // Advance the position and update both running sums and counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
            lsum   <= '0;
            gsum   <= '0;
            lcnt   <= '0;
            gcnt   <= '0;
        end else if (go) begin
            active <= 1'b1;
            pos    <= ZERO - g_s - t_s - ONE;
            lsum   <= '0;
            gsum   <= '0;
            lcnt   <= '0;
            gcnt   <= '0;
        end else if (active) begin
            pos  <= pos + ONE;
            lsum <= lsum + SUM_W'(d_la) - SUM_W'(d_lr);
            gsum <= gsum + SUM_W'(d_ga) - SUM_W'(d_gr);
            lcnt <= lcnt + TRAIN_W'(v_la) - TRAIN_W'(v_lr);
            gcnt <= gcnt + TRAIN_W'(v_ga) - TRAIN_W'(v_gr);
            if (em_last) begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cfar_threshold.sv
// Noise estimate and threshold decision in four register stages:
// 1) cross products of each side's sum by the opposite count,
// 2) selection of sum and count by mode,
// 3) mag*count*2^FRAC and alpha*sum,
// 4) strict compare.
// Assumes mode and alpha stay constant while a frame is in flight.
module cfar_threshold #(
    parameter int MAG_W      = 17,
    parameter int AW         = 11,
    parameter int TRAIN_W    = 6,
    parameter int ALPHA_W    = 8,
    parameter int ALPHA_FRAC = 4,
    localparam int SUM_W     = MAG_W + TRAIN_W,
    localparam int XP_W      = SUM_W + TRAIN_W,
    localparam int CMP_W     = MAG_W + TRAIN_W + ALPHA_W + ALPHA_FRAC + 2,
    localparam int LAT       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode,
    input  logic [ALPHA_W-1:0]  alpha,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic [AW-1:0]       in_idx,
    input  logic [MAG_W-1:0]    in_mag,
    input  logic [SUM_W-1:0]    in_lsum,
    input  logic [SUM_W-1:0]    in_gsum,
    input  logic [TRAIN_W-1:0]  in_lcnt,
    input  logic [TRAIN_W-1:0]  in_gcnt,
    output logic                out_valid,
    output logic                out_hit,
    output logic [AW-1:0]       out_idx,
    output logic [MAG_W-1:0]    out_mag,
    output logic                out_last
);
    import cfar_pkg::*;

    logic [LAT-1:0]     m_v, m_last;
    logic [AW-1:0]      m_idx [LAT];
    logic [MAG_W-1:0]   m_mag [LAT];

    logic [SUM_W-1:0]   s1_lsum, s1_gsum;
    logic [TRAIN_W-1:0] s1_lcnt, s1_gcnt;
    logic [XP_W-1:0]    s1_pl, s1_pg;
    logic [SUM_W:0]     s2_sum, sel_sum;
    logic [TRAIN_W:0]   s2_cnt, sel_cnt;
    logic [CMP_W-1:0]   s3_lhs, s3_rhs;
    logic               hit_q;
    logic               take_l;
    cfar_mode_e         mode_e;

    assign mode_e = cfar_mode_e'(mode);

    // Cell metadata travels alongside the arithmetic stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_v    <= '0;
            m_last <= '0;
        end else begin
            m_v[0]    <= in_valid;
            m_last[0] <= in_valid && in_last;
            for (int k = 1; k < LAT; k++) begin
                m_v[k]    <= m_v[k-1];
                m_last[k] <= m_last[k-1];
            end
        end
    end

    // Index and magnitude carried alongside the arithmetic stages.
    always_ff @(posedge clk) begin
        m_idx[0] <= in_idx;
        m_mag[0] <= in_mag;
        for (int k = 1; k < LAT; k++) begin
            m_idx[k] <= m_idx[k-1];
            m_mag[k] <= m_mag[k-1];
        end
    end

    // Stage 1: cross products for the greatest-of / smallest-of choice.
    always_ff @(posedge clk) begin
        s1_lsum <= in_lsum;
        s1_gsum <= in_gsum;
        s1_lcnt <= in_lcnt;
        s1_gcnt <= in_gcnt;
        s1_pl   <= XP_W'(in_lsum) * XP_W'(in_gcnt);
        s1_pg   <= XP_W'(in_gsum) * XP_W'(in_lcnt);
    end

    // Side choice: an empty side yields to the other, otherwise compare means.
    always_comb begin
        if (s1_lcnt == '0) begin
            take_l = 1'b0;
        end else if (s1_gcnt == '0) begin
            take_l = 1'b1;
        end else if (mode_e == MODE_GO) begin
            take_l = (s1_pl >= s1_pg);
        end else begin
            take_l = (s1_pl <= s1_pg);
        end
    end

    // Noise sum and count picked by the configured mode.
    always_comb begin
        case (mode_e)
            MODE_GO, MODE_SO: begin
                sel_sum = take_l ? (SUM_W+1)'(s1_lsum) : (SUM_W+1)'(s1_gsum);
                sel_cnt = take_l ? (TRAIN_W+1)'(s1_lcnt) : (TRAIN_W+1)'(s1_gcnt);
            end
            default: begin
                sel_sum = (SUM_W+1)'(s1_lsum) + (SUM_W+1)'(s1_gsum);
                sel_cnt = (TRAIN_W+1)'(s1_lcnt) + (TRAIN_W+1)'(s1_gcnt);
            end
        endcase
    end

    // Stage 2: register the selected estimate.
    always_ff @(posedge clk) begin
        s2_sum <= sel_sum;
        s2_cnt <= sel_cnt;
    end

    // Stage 3: both sides of the division-free threshold inequality.
    always_ff @(posedge clk) begin
        s3_lhs <= (CMP_W'(m_mag[1]) * CMP_W'(s2_cnt)) << ALPHA_FRAC;
        s3_rhs <= CMP_W'(alpha) * CMP_W'(s2_sum);
    end

    // Stage 4: strict compare, forced low when no result is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= m_v[2] && (s3_lhs > s3_rhs);
        end
    end

    assign out_valid = m_v[LAT-1];
    assign out_last  = m_last[LAT-1];
    assign out_idx   = m_idx[LAT-1];
    assign out_mag   = m_mag[LAT-1];
    assign out_hit   = hit_q;
endmodule

// File: rtl/cfar_detector.sv
// CFAR detector top. Sequence: fill the buffer from the input stream,
// latching configuration with the first sample. Then scan every cell
// through the window engine, then drain the noise pipeline until the
// final result leaves. Input samples are accepted only while filling.
module cfar_detector #(
    parameter int MAG_W      = 17,
    parameter int DEPTH      = 2048,
    parameter int GUARD_W    = 4,
    parameter int TRAIN_W    = 6,
    parameter int ALPHA_W    = 8,
    parameter int ALPHA_FRAC = 4,
    localparam int AW        = $clog2(DEPTH),
    localparam int SUM_W     = MAG_W + TRAIN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [MAG_W-1:0]    in_mag,
    input  logic                in_last,
    input  logic [1:0]          cfg_mode,
    input  logic [GUARD_W-1:0]  cfg_guard,
    input  logic [TRAIN_W-1:0]  cfg_train,
    input  logic [ALPHA_W-1:0]  cfg_alpha,
    output logic                out_valid,
    output logic                out_hit,
    output logic [AW-1:0]       out_idx,
    output logic [MAG_W-1:0]    out_mag,
    output logic                out_last
);
    import cfar_pkg::*;

    cfar_state_e           state;
    logic [AW:0]           wr_cnt, n_len;
    logic [1:0]            mode_q;
    logic [GUARD_W-1:0]    guard_q;
    logic [TRAIN_W-1:0]    train_q;
    logic [ALPHA_W-1:0]    alpha_q;
    logic                  go_q;
    logic                  st_fill, accept, fill_end;

    logic [4:0][AW-1:0]    rd_addr;
    logic [4:0][MAG_W-1:0] rd_data;

    logic                  em_valid, em_last;
    logic [AW-1:0]         em_idx;
    logic [MAG_W-1:0]      em_mag;
    logic [SUM_W-1:0]      em_lsum, em_gsum;
    logic [TRAIN_W-1:0]    em_lcnt, em_gcnt;

    assign st_fill  = (state == ST_FILL);
    assign accept   = st_fill && in_valid;
    assign fill_end = accept && (in_last || (wr_cnt == (AW+1)'(DEPTH-1)));

    // Frame sequencing: fill, scan, drain, back to fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FILL;
            wr_cnt <= '0;
            n_len  <= '0;
            go_q   <= 1'b0;
        end else begin
            go_q <= fill_end;
            case (state)
                ST_FILL: begin
                    if (fill_end) begin
                        n_len  <= wr_cnt + 1'b1;
                        wr_cnt <= '0;
                        state  <= ST_SCAN;
                    end else if (accept) begin
                        wr_cnt <= wr_cnt + 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (em_last) begin
                        state <= ST_DRAIN;
                    end
                end
                default: begin
                    if (out_valid && out_last) begin
                        state <= ST_FILL;
                    end
                end
            endcase
        end
    end

    // Configuration is captured only with the first sample of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            guard_q <= '0;
            train_q <= '0;
            alpha_q <= '0;
        end else if (accept && (wr_cnt == '0)) begin
            mode_q  <= cfg_mode;
            guard_q <= cfg_guard;
            train_q <= cfg_train;
            alpha_q <= cfg_alpha;
        end
    end

    cfar_mag_store #(
        .MAG_W (MAG_W),
        .DEPTH (DEPTH),
        .NRD   (5)
    ) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (wr_cnt[AW-1:0]),
        .wr_data (in_mag),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cfar_window #(
        .MAG_W   (MAG_W),
        .AW      (AW),
        .GUARD_W (GUARD_W),
        .TRAIN_W (TRAIN_W)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go_q),
        .n_len    (n_len),
        .guard    (guard_q),
        .train    (train_q),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .em_valid (em_valid),
        .em_last  (em_last),
        .em_idx   (em_idx),
        .em_mag   (em_mag),
        .em_lsum  (em_lsum),
        .em_gsum  (em_gsum),
        .em_lcnt  (em_lcnt),
        .em_gcnt  (em_gcnt)
    );

    cfar_threshold #(
        .MAG_W      (MAG_W),
        .AW         (AW),
        .TRAIN_W    (TRAIN_W),
        .ALPHA_W    (ALPHA_W),
        .ALPHA_FRAC (ALPHA_FRAC)
    ) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .alpha     (alpha_q),
        .in_valid  (em_valid),
        .in_last   (em_last),
        .in_idx    (em_idx),
        .in_mag    (em_mag),
        .in_lsum   (em_lsum),
        .in_gsum   (em_gsum),
        .in_lcnt   (em_lcnt),
        .in_gcnt   (em_gcnt),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_idx   (out_idx),
        .out_mag   (out_mag),
        .out_last  (out_last)
    );
endmodule

// File: rtl/cfar_detector_chk.sv
// Protocol checker for the CFAR detector result stream, bound to the top.
// It tracks the index expected next and the fill phase of the control.
module cfar_detector_chk #(
    parameter int AW    = 11,
    parameter int MAG_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_hit,
    input logic [AW-1:0]    out_idx,
    input logic [MAG_W-1:0] out_mag,
    input logic             out_last,
    input logic             filling
);
    logic [AW-1:0] exp_idx;

    // Expected index of the next result in the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_idx <= '0;
        end else if (out_valid) begin
            exp_idx <= out_last ? '0 : exp_idx + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid); // R1
    AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_idx == exp_idx); // R2
    AST_LAST_GAP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_last) |=> !out_valid); // R2
    AST_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_mag == '0) |-> !out_hit); // R8
    AST_HIT_QUAL: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> !out_hit); // R12
    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) filling |-> !out_valid); // R11
endmodule

bind cfar_detector cfar_detector_chk #(
    .AW    (AW),
    .MAG_W (MAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_idx   (out_idx),
    .out_mag   (out_mag),
    .out_last  (out_last),
    .filling   (st_fill)
);

// File: tb/test_cfar_detector.sv
// Scoreboard bench: the driver task computes expected results from the
// requirements and queues them; the monitor compares each result as it leaves.
module test_cfar_detector;
    localparam int MAG_W   = 17;
    localparam int DEPTH   = 32;
    localparam int AW      = 5;
    localparam int GUARD_W = 4;
    localparam int TRAIN_W = 6;
    localparam int ALPHA_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [MAG_W-1:0]   in_mag = '0;
    logic               in_last = 1'b0;
    logic [1:0]         cfg_mode = '0;
    logic [GUARD_W-1:0] cfg_guard = '0;
    logic [TRAIN_W-1:0] cfg_train = '0;
    logic [ALPHA_W-1:0] cfg_alpha = '0;
    logic               out_valid, out_hit, out_last;
    logic [AW-1:0]      out_idx;
    logic [MAG_W-1:0]   out_mag;

    typedef struct {
        int    idx;
        int    mag;
        bit    hit;
        bit    last;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    fbuf[64];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    cfar_detector #(
        .MAG_W   (MAG_W),
        .DEPTH   (DEPTH),
        .GUARD_W (GUARD_W),
        .TRAIN_W (TRAIN_W),
        .ALPHA_W (ALPHA_W)
    ) i_cfar_detector (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mag    (in_mag),
        .in_last   (in_last),
        .cfg_mode  (cfg_mode),
        .cfg_guard (cfg_guard),
        .cfg_train (cfg_train),
        .cfg_alpha (cfg_alpha),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_idx   (out_idx),
        .out_mag   (out_mag),
        .out_last  (out_last)
    );

    // Reference decision written from the window and mode rules (R4-R9).
    function automatic bit ref_hit(int i, int n, int g, int t, int md, int al);
        longint sl, sg, s, c;
        int     cl, cg;
        real    ml, mg;
        bit     use_l;
        sl = 0; sg = 0; cl = 0; cg = 0;
        for (int j = i - g - t; j <= i - g - 1; j++)
            if (j >= 0 && j < n) begin sl += fbuf[j]; cl++; end
        for (int j = i + g + 1; j <= i + g + t; j++)
            if (j >= 0 && j < n) begin sg += fbuf[j]; cg++; end
        if (md == 1 || md == 2) begin
            if (cl == 0) use_l = 1'b0;
            else if (cg == 0) use_l = 1'b1;
            else begin
                ml = real'(sl) / real'(cl);
                mg = real'(sg) / real'(cg);
                use_l = (md == 1) ? (ml >= mg) : (ml <= mg);
            end
            s = use_l ? sl : sg;
            c = use_l ? cl : cg;
        end else begin
            s = sl + sg;
            c = cl + cg;
        end
        return (longint'(fbuf[i]) * c * 16) > (longint'(al) * s);
    endfunction

    // Driver: queue expected results, then stream the frame in.
    task automatic send_frame(input int n, input int md, input int g, input int t,
                              input int al, input string tag, input bit use_last,
                              input int garbage, input bit flip);
        int   nn;
        exp_t e;
        nn = (n > DEPTH) ? DEPTH : n;
        for (int i = 0; i < nn; i++) begin
            e.idx  = i;
            e.mag  = fbuf[i];
            e.hit  = ref_hit(i, nn, g, t, md, al);
            e.last = (i == nn - 1);
            e.tag  = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        cfg_mode  = 2'(md);
        cfg_guard = GUARD_W'(g);
        cfg_train = TRAIN_W'(t);
        cfg_alpha = ALPHA_W'(al);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            in_valid = 1'b1;
            in_mag   = MAG_W'(fbuf[i]);
            in_last  = use_last && (i == n - 1);
            if (flip && i == 1) begin
                cfg_mode  = 2'd2;
                cfg_alpha = '0;
                cfg_guard = '0;
                cfg_train = TRAIN_W'(1);
            end
        end
        for (int i = 0; i < garbage; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_mag   = MAG_W'(17'h1F000 + i);
            in_last  = i[0];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare every produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected result actual idx=%0d mag=%0d expected none",
                         out_idx, out_mag);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (int'(out_idx) != e.idx || int'(out_mag) != e.mag ||
                    out_hit != e.hit || out_last != e.last) begin
                    n_fail++;
                    $display("FAIL %s actual idx=%0d mag=%0d hit=%0b last=%0b expected idx=%0d mag=%0d hit=%0b last=%0b",
                             e.tag, out_idx, out_mag, out_hit, out_last,
                             e.idx, e.mag, e.hit, e.last);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int quiet_bad;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 out_valid in reset actual=%0b expected=0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 out_valid after reset actual=%0b expected=0", out_valid);
        end

        // Averaging on a textured profile with two targets (R2 R4 R5 R12).
        for (int i = 0; i < 24; i++) fbuf[i] = 8 + (i * 5) % 7;
        fbuf[8] = 80; fbuf[17] = 40; fbuf[0] = 30;
        send_frame(24, 0, 1, 3, 48, "R2 R4 R5 R12", 1'b1, 0, 1'b0);
        wait_done();
        send_frame(24, 3, 1, 3, 40, "R5 mode3", 1'b1, 0, 1'b0);
        wait_done();

        // Step profile: greatest-of and smallest-of differ at the step (R6 R7).
        for (int i = 0; i < 24; i++) fbuf[i] = (i < 12) ? 5 : 50;
        fbuf[9] = 60; fbuf[20] = 70;
        send_frame(24, 1, 0, 4, 24, "R6", 1'b1, 0, 1'b0);
        wait_done();
        send_frame(24, 2, 0, 4, 24, "R7", 1'b1, 0, 1'b0);
        wait_done();
        // Samples offered during the scan are ignored (R11).
        send_frame(24, 1, 2, 3, 20, "R11", 1'b1, 5, 1'b0);
        wait_done();

        // Equality, zero magnitude and empty windows (R8).
        for (int i = 0; i < 12; i++) fbuf[i] = 4;
        fbuf[6] = 5; fbuf[10] = 0; fbuf[11] = 0;
        send_frame(12, 0, 1, 2, 16, "R8", 1'b1, 0, 1'b0);
        wait_done();
        fbuf[0] = 1000;
        send_frame(1, 0, 0, 3, 16, "R8 single", 1'b1, 0, 1'b0);
        wait_done();

        // Fractional scale 1.5: 15 over mean 10 misses, 16 hits (R9).
        for (int i = 0; i < 20; i++) fbuf[i] = 10;
        fbuf[5] = 15; fbuf[14] = 16;
        send_frame(20, 0, 0, 2, 24, "R9", 1'b1, 0, 1'b0);
        wait_done();

        // Configuration changed after the first sample has no effect (R10).
        for (int i = 0; i < 24; i++) fbuf[i] = 8 + (i * 3) % 5;
        fbuf[11] = 60;
        send_frame(24, 0, 1, 3, 48, "R10", 1'b1, 0, 1'b1);
        wait_done();

        // Frame longer than the buffer ends at DEPTH-1 (R3).
        for (int i = 0; i < DEPTH + 3; i++) fbuf[i] = 3 + (i * 7) % 23;
        fbuf[DEPTH - 1] = 200; fbuf[12] = 150;
        send_frame(DEPTH + 3, 0, 1, 4, 32, "R3", 1'b0, 0, 1'b0);
        wait_done();

        // Reset in the middle of a fill discards that frame (R1).
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_mag   = MAG_W'(i + 1);
            in_last  = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        quiet_bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_valid) quiet_bad++;
        end
        n_checks++;
        if (quiet_bad != 0) begin
            n_fail++;
            $display("FAIL R1 results after mid-frame reset actual=%0d expected=0", quiet_bad);
        end
        for (int i = 0; i < 16; i++) fbuf[i] = 6 + (i % 3);
        fbuf[7] = 90;
        send_frame(16, 2, 1, 2, 32, "R1 restart", 1'b1, 0, 1'b0);
        wait_done();

        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing results actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule